// File: doc/BRIEF.md
# Legacy Memory Region Attribute Decoder

This block sits between an address source and the memory and legacy-bus paths of a chip. It sorts every 20-bit physical address into one of three targets: main memory with read and write allowed, main memory with writes blocked, or the legacy expansion bus. The upper area from 0xC0000 to 0xFFFFF is split into twelve 16 KB segments and one 64 KB top segment. Each segment has a 2-bit attribute code held in a small bank of configuration bytes. The 128 KB graphics window at 0xA0000-0xBFFFF is opened to main memory through a control byte, either always or only while system-management mode is active.

The configuration bytes are loaded through a byte-wide write port. A write lands on the next clock edge and the decode follows it at once. The decode itself is combinational from the address, the stored bytes and the system-management-mode input, so a change of mode takes effect in the same cycle. Access strobes qualify the route with the access direction. A write into a write-blocked segment is reported as dropped and does not strobe memory.

Top module: `legacy_window_decoder`

## Requirements
- R1: Addresses below 0xA0000 always decode to main memory read/write (route 2'b11), whatever the configuration bytes or the mode input hold.
- R2: The top segment 0xF0000-0xFFFFF takes its attribute code from bits 5:4 of the byte at offset 0x59; the other bits of that byte have no effect on any route.
- R3: Segment i (0 to 11) covers 0xC0000 + i*0x4000 for 16 KB and takes its code from the byte at offset 0x5A + (i>>1): bits 1:0 when i is even, bits 5:4 when i is odd. Bits 3:2 and 7:6 have no effect.
- R4: Attribute code 3 gives route 2'b11 (memory read/write), code 1 gives route 2'b01 (memory read-only), and codes 0 and 2 give route 2'b00 (legacy bus).
- R5: The window 0xA0000-0xBFFFF gives route 2'b11 when bit 6 of the byte at offset 0x72 is set, or when the mode input is high and bit 3 of that byte is set; otherwise it gives route 2'b00.
- R6: After reset the byte at 0x72 holds 0x02 and the bytes at 0x59-0x5F hold 0x00, so the window and every segment decode to the legacy bus.
- R7: A configuration write to offset 0x59-0x5F or 0x72 changes the decode from the cycle after its clock edge; writes to any other offset change no route.
- R8: A change of the mode input changes the window route in the same cycle, with no clock edge needed.
- R9: A valid write to a route-2'b01 address raises wr_drop_o and keeps mem_we_o low; a valid read of such an address raises mem_rd_o.
- R10: With acc_valid high, mem_rd_o is set for a read to either memory route, mem_we_o for a write to route 2'b11, bus_cyc_o for any access to route 2'b00; at most one of these and wr_drop_o is high, and all are low when acc_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write enable |
| cfg_ofs | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration byte data |
| smm_active | input | 1 | System-management mode is active |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | Access is a write (1) or read (0) |
| acc_addr | input | 20 | Physical address of the access |
| route_o | output | 2 | Target: 2'b11 memory RW, 2'b01 memory RO, 2'b00 legacy bus |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| wr_drop_o | output | 1 | Write to read-only memory discarded |
| bus_cyc_o | output | 1 | Access forwarded to the legacy bus |

## Verification
Directed addresses sit on each region edge (0x9FFFF/0xA0000, 0xBFFFF/0xC0000, the 0x4000 steps between neighbouring segments, 0xEFFFF/0xF0000), which tells an off-by-one segment index or a swapped nibble apart from a correct decode. Attribute bytes are loaded with values whose ignored bits are set and whose used bits differ between the two nibbles, so a decode that reads the wrong bits or the wrong half shows a different route. The mode input is toggled within a cycle under each setting of the two window control bits, which separates the always-open case from the mode-gated case. A long run of seeded random writes, some to offsets outside the bank, mixed with random addresses and directions, compares all five outputs against a bench model.

// File: rtl/legacy_dec_pkg.sv
package legacy_dec_pkg;

   typedef enum logic [1:0] {
      ROUTE_BUS    = 2'b00,
      ROUTE_MEM_RO = 2'b01,
      ROUTE_MEM_RW = 2'b11
   } route_t;

   typedef enum logic [1:0] {
      REGION_LOW = 2'd0,
      REGION_WIN = 2'd1,
      REGION_SEG = 2'd2,
      REGION_TOP = 2'd3
   } region_t;

   // 2-bit attribute code to target: 3 -> RW, 1 -> RO, 0 and 2 -> bus
   function automatic route_t attr_to_route(input logic [1:0] code);
      route_t r;
      case (code)
         2'b11:   r = ROUTE_MEM_RW;
         2'b01:   r = ROUTE_MEM_RO;
         default: r = ROUTE_BUS;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/ldec_cfg_regs.sv
module ldec_cfg_regs #(
   parameter int          NUM_BYTES  = 7,
   parameter logic [7:0]  ATTR_OFS   = 8'h59,
   parameter logic [7:0]  SMRAM_OFS  = 8'h72,
   parameter logic [7:0]  SMRAM_INIT = 8'h02
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [7:0]             cfg_ofs,
   input  logic [7:0]             cfg_wdata,
   output logic [NUM_BYTES*8-1:0] attr_bytes_o,
   output logic [7:0]             smram_o
);

   // one register per attribute byte, each with its own decoded offset
   for (genvar g = 0; g < NUM_BYTES; g++) begin : g_attr
      localparam logic [7:0] MY_OFS = 8'(int'(ATTR_OFS) + g);
      logic [7:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= 8'h00;
         else if (cfg_we && (cfg_ofs == MY_OFS))
            q <= cfg_wdata;
      end
      assign attr_bytes_o[g*8 +: 8] = q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         smram_o <= SMRAM_INIT;
      else if (cfg_we && (cfg_ofs == SMRAM_OFS))
         smram_o <= cfg_wdata;
   end

endmodule

// File: rtl/ldec_seg_attr.sv
module ldec_seg_attr #(
   parameter int NUM_SEGS = 12,
   parameter int TOP_LSB  = 4,
   localparam int NUM_BYTES = 1 + NUM_SEGS / 2
) (
   input  logic [NUM_BYTES*8-1:0] attr_bytes_i,
   output logic [NUM_SEGS*2-1:0]  seg_code_o,
   output logic [1:0]             top_code_o
);

   // byte 0 carries the top segment; segments pack two per following byte
   assign top_code_o = attr_bytes_i[TOP_LSB +: 2];

   for (genvar i = 0; i < NUM_SEGS; i++) begin : g_seg
      localparam int BYTE_IDX = 1 + i / 2;
      localparam int NIB_LSB  = (i % 2) * 4;
      assign seg_code_o[2*i +: 2] = attr_bytes_i[BYTE_IDX*8 + NIB_LSB +: 2];
   end

   logic unused_attr_bits;
   assign unused_attr_bits = ^attr_bytes_i;

endmodule

// File: rtl/ldec_window_gate.sv
module ldec_window_gate #(
   parameter int OPEN_BIT = 6,
   parameter int SMM_BIT  = 3
) (
   input  logic [7:0] smram_i,
   input  logic       smm_active_i,
   output logic       win_open_o
);

   assign win_open_o = smram_i[OPEN_BIT] | (smm_active_i & smram_i[SMM_BIT]);

   logic unused_smram_bits;
   assign unused_smram_bits = ^smram_i;

endmodule

// File: rtl/ldec_addr_classify.sv
module ldec_addr_classify
   import legacy_dec_pkg::*;
#(
   parameter int                ADDR_W    = 20,
   parameter int                NUM_SEGS  = 12,
   parameter int                SEG_BITS  = 14,
   parameter logic [ADDR_W-1:0] WIN_BASE  = 20'hA0000,
   parameter logic [ADDR_W-1:0] SEG_BASE  = 20'hC0000,
   parameter logic [ADDR_W-1:0] TOP_BASE  = 20'hF0000,
   localparam int               SEG_IDX_W = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
   input  logic [ADDR_W-1:0]    addr_i,
   output region_t              region_o,
   output logic [SEG_IDX_W-1:0] seg_idx_o
);

   logic [ADDR_W-1:0] seg_off;

   always_comb begin
      if (addr_i < WIN_BASE)
         region_o = REGION_LOW;
      else if (addr_i < SEG_BASE)
         region_o = REGION_WIN;
      else if (addr_i < TOP_BASE)
         region_o = REGION_SEG;
      else
         region_o = REGION_TOP;
   end

   assign seg_off   = addr_i - SEG_BASE;
   assign seg_idx_o = seg_off[SEG_BITS +: SEG_IDX_W];

   logic unused_off_bits;
   assign unused_off_bits = ^seg_off;

endmodule

// File: rtl/legacy_window_decoder.sv
module legacy_window_decoder
   import legacy_dec_pkg::*;
#(
   parameter int                ADDR_W     = 20,
   parameter int                NUM_SEGS   = 12,
   parameter int                SEG_BITS   = 14,
   parameter logic [ADDR_W-1:0] WIN_BASE   = 20'hA0000,
   parameter logic [ADDR_W-1:0] SEG_BASE   = 20'hC0000,
   parameter logic [ADDR_W-1:0] TOP_BASE   = 20'hF0000,
   parameter logic [7:0]        ATTR_OFS   = 8'h59,
   parameter logic [7:0]        SMRAM_OFS  = 8'h72,
   parameter logic [7:0]        SMRAM_INIT = 8'h02,
   parameter int                TOP_LSB    = 4,
   parameter int                OPEN_BIT   = 6,
   parameter int                SMM_BIT    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_ofs,
   input  logic [7:0]        cfg_wdata,
   input  logic              smm_active,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic [1:0]        route_o,
   output logic              mem_rd_o,
   output logic              mem_we_o,
   output logic              wr_drop_o,
   output logic              bus_cyc_o
);

   localparam int NUM_BYTES = 1 + NUM_SEGS / 2;
   localparam int SEG_IDX_W = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1;

   // elaboration-time parameter checks
   if (NUM_SEGS % 2 != 0) begin : g_chk_even
      $error("NUM_SEGS must be even: segments pack two per byte");
   end
   if ((int'(SEG_BASE) + (NUM_SEGS << SEG_BITS)) != int'(TOP_BASE)) begin : g_chk_span
      $error("segment span must end exactly at TOP_BASE");
   end
   if (!(WIN_BASE < SEG_BASE)) begin : g_chk_order
      $error("window must lie below the segment area");
   end
   if (TOP_LSB > 6 || OPEN_BIT > 7 || SMM_BIT > 7) begin : g_chk_bits
      $error("control bit positions out of byte range");
   end

   logic [NUM_BYTES*8-1:0] attr_bytes;
   logic [7:0]             smram_byte;
   logic [NUM_SEGS*2-1:0]  seg_code;
   logic [1:0]             top_code;
   logic                   win_open;
   region_t                region;
   logic [SEG_IDX_W-1:0]   seg_idx;
   route_t                 route;

   ldec_cfg_regs #(
      .NUM_BYTES  (NUM_BYTES),
      .ATTR_OFS   (ATTR_OFS),
      .SMRAM_OFS  (SMRAM_OFS),
      .SMRAM_INIT (SMRAM_INIT)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_ofs      (cfg_ofs),
      .cfg_wdata    (cfg_wdata),
      .attr_bytes_o (attr_bytes),
      .smram_o      (smram_byte)
   );

   ldec_seg_attr #(
      .NUM_SEGS (NUM_SEGS),
      .TOP_LSB  (TOP_LSB)
   ) u_seg (
      .attr_bytes_i (attr_bytes),
      .seg_code_o   (seg_code),
      .top_code_o   (top_code)
   );

   ldec_window_gate #(
      .OPEN_BIT (OPEN_BIT),
      .SMM_BIT  (SMM_BIT)
   ) u_win (
      .smram_i      (smram_byte),
      .smm_active_i (smm_active),
      .win_open_o   (win_open)
   );

   ldec_addr_classify #(
      .ADDR_W   (ADDR_W),
      .NUM_SEGS (NUM_SEGS),
      .SEG_BITS (SEG_BITS),
      .WIN_BASE (WIN_BASE),
      .SEG_BASE (SEG_BASE),
      .TOP_BASE (TOP_BASE)
   ) u_cls (
      .addr_i    (acc_addr),
      .region_o  (region),
      .seg_idx_o (seg_idx)
   );

   always_comb begin
      case (region)
         REGION_LOW: route = ROUTE_MEM_RW;
         REGION_WIN: route = win_open ? ROUTE_MEM_RW : ROUTE_BUS;
         REGION_SEG: route = attr_to_route(seg_code[2*seg_idx +: 2]);
         default:    route = attr_to_route(top_code);
      endcase
   end

   assign route_o   = route;
   assign mem_rd_o  = acc_valid & ~acc_write & (route != ROUTE_BUS);
   assign mem_we_o  = acc_valid &  acc_write & (route == ROUTE_MEM_RW);
   assign wr_drop_o = acc_valid &  acc_write & (route == ROUTE_MEM_RO);
   assign bus_cyc_o = acc_valid & (route == ROUTE_BUS);

endmodule

// File: rtl/ldec_checker.sv
module ldec_checker #(
   parameter int                ADDR_W    = 20,
   parameter logic [ADDR_W-1:0] WIN_BASE  = 20'hA0000,
   parameter logic [ADDR_W-1:0] SEG_BASE  = 20'hC0000,
   parameter logic [7:0]        SMRAM_OFS = 8'h72,
   parameter int                OPEN_BIT  = 6,
   parameter int                SMM_BIT   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [7:0]        cfg_ofs,
   input logic              smm_active,
   input logic              acc_valid,
   input logic              acc_write,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [1:0]        route_o,
   input logic              mem_rd_o,
   input logic              mem_we_o,
   input logic              wr_drop_o,
   input logic              bus_cyc_o,
   input logic [7:0]        smram_byte
);

   logic in_win;
   assign in_win = (acc_addr >= WIN_BASE) && (acc_addr < SEG_BASE);

   assert_low_rw_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_addr < WIN_BASE) |-> (route_o == 2'b11));

   assert_win_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && !smram_byte[OPEN_BIT] && !(smm_active && smram_byte[SMM_BIT]))
      |-> (route_o == 2'b00));

   assert_win_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && smram_byte[OPEN_BIT]) |-> (route_o == 2'b11));

   assert_other_ofs_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (cfg_ofs != SMRAM_OFS)) |=> $stable(smram_byte));

   assert_ro_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && (route_o == 2'b01)) |-> (wr_drop_o && !mem_we_o));

   assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd_o, mem_we_o, wr_drop_o, bus_cyc_o}));

   assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> !(mem_rd_o || mem_we_o || wr_drop_o || bus_cyc_o));

endmodule

bind legacy_window_decoder ldec_checker #(
   .ADDR_W    (ADDR_W),
   .WIN_BASE  (WIN_BASE),
   .SEG_BASE  (SEG_BASE),
   .SMRAM_OFS (SMRAM_OFS),
   .OPEN_BIT  (OPEN_BIT),
   .SMM_BIT   (SMM_BIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_we     (cfg_we),
   .cfg_ofs    (cfg_ofs),
   .smm_active (smm_active),
   .acc_valid  (acc_valid),
   .acc_write  (acc_write),
   .acc_addr   (acc_addr),
   .route_o    (route_o),
   .mem_rd_o   (mem_rd_o),
   .mem_we_o   (mem_we_o),
   .wr_drop_o  (wr_drop_o),
   .bus_cyc_o  (bus_cyc_o),
   .smram_byte (smram_byte)
);

// File: tb/legacy_window_decoder_test.sv
module legacy_window_decoder_test;

   localparam int CLK_PERIOD = 10;
   localparam int N_RANDOM   = 4000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_ofs = 8'h00;
   logic [7:0]  cfg_wdata = 8'h00;
   logic        smm_active = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [19:0] acc_addr = 20'h0;
   logic [1:0]  route_o;
   logic        mem_rd_o, mem_we_o, wr_drop_o, bus_cyc_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] m_cfg [0:255];

   always #(CLK_PERIOD/2) clk = ~clk;

   legacy_window_decoder uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ofs(cfg_ofs),
      .cfg_wdata(cfg_wdata), .smm_active(smm_active), .acc_valid(acc_valid),
      .acc_write(acc_write), .acc_addr(acc_addr), .route_o(route_o),
      .mem_rd_o(mem_rd_o), .mem_we_o(mem_we_o), .wr_drop_o(wr_drop_o),
      .bus_cyc_o(bus_cyc_o)
   );

   function automatic logic [1:0] code_route(input logic [1:0] c);
      if (c == 2'd3) return 2'b11;
      if (c == 2'd1) return 2'b01;
      return 2'b00;
   endfunction

   function automatic logic [1:0] exp_route(input logic [19:0] a, input logic smm);
      int seg;
      logic [7:0] b;
      if (a < 20'hA0000) return 2'b11;
      if (a < 20'hC0000)
         return (m_cfg[8'h72][6] || (smm && m_cfg[8'h72][3])) ? 2'b11 : 2'b00;
      if (a < 20'hF0000) begin
         seg = int'((a - 20'hC0000) >> 14);
         b = m_cfg[8'h5A + seg / 2];
         return code_route((seg % 2 == 1) ? b[5:4] : b[1:0]);
      end
      return code_route(m_cfg[8'h59][5:4]);
   endfunction

   function automatic string region_tag(input logic [19:0] a);
      if (a < 20'hA0000) return "R1";
      if (a < 20'hC0000) return "R5";
      if (a < 20'hF0000) return "R3";
      return "R2";
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 256; i++) m_cfg[i] = 8'h00;
      m_cfg[8'h72] = 8'h02;
   endtask

   // drive at the falling edge, check 1 time unit later, clock the write in
   task automatic step(input logic we, input logic [7:0] ofs, input logic [7:0] wd,
                       input logic smm, input logic v, input logic wr,
                       input logic [19:0] a, input string tag);
      logic [1:0] er;
      logic erd, ewe, edr, ebc;
      @(negedge clk);
      cfg_we = we; cfg_ofs = ofs; cfg_wdata = wd;
      smm_active = smm; acc_valid = v; acc_write = wr; acc_addr = a;
      #1;
      er  = exp_route(a, smm);
      erd = v && !wr && (er != 2'b00);
      ewe = v && wr && (er == 2'b11);
      edr = v && wr && (er == 2'b01);
      ebc = v && (er == 2'b00);
      checks++;
      if (route_o !== er || mem_rd_o !== erd || mem_we_o !== ewe ||
          wr_drop_o !== edr || bus_cyc_o !== ebc) begin
         errors++;
         $display("FAIL %s addr=%05h smm=%0b route/rd/we/drop/bus got %b %b %b %b %b exp %b %b %b %b %b",
                  tag, a, smm, route_o, mem_rd_o, mem_we_o, wr_drop_o, bus_cyc_o,
                  er, erd, ewe, edr, ebc);
      end
      @(posedge clk);
      if (we && (((ofs >= 8'h59) && (ofs <= 8'h5F)) || ofs == 8'h72))
         m_cfg[ofs] = wd;
   endtask

   task automatic probe(input logic [19:0] a, input logic smm, input logic wr, input string tag);
      step(1'b0, 8'h00, 8'h00, smm, 1'b1, wr, a, tag);
   endtask

   task automatic cfg(input logic [7:0] ofs, input logic [7:0] wd);
      step(1'b1, ofs, wd, 1'b0, 1'b0, 1'b0, 20'h00000, "R10");
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int unused_seed;
      unused_seed = int'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R6: reset state, every region except low memory on the bus
      probe(20'hA0000, 1'b1, 1'b0, "R6");
      probe(20'hBFFFF, 1'b0, 1'b0, "R6");
      for (int s = 0; s < 12; s++)
         probe(20'hC0000 + 20'(s) * 20'h4000, 1'b0, 1'b0, "R6");
      probe(20'hF0000, 1'b0, 1'b0, "R6");
      probe(20'hFFFFF, 1'b0, 1'b1, "R6");

      // R1: boundary just below the window
      probe(20'h9FFFF, 1'b0, 1'b1, "R1");
      probe(20'h00000, 1'b1, 1'b0, "R1");

      // R3 R4: seg0 code 1 (RO), seg1 code 3 (RW), ignored bits set on seg2/3
      cfg(8'h5A, 8'h31);
      probe(20'hC0000, 1'b0, 1'b0, "R3");
      probe(20'hC3FFF, 1'b0, 1'b1, "R9");
      probe(20'hC4000, 1'b0, 1'b1, "R4");
      cfg(8'h5B, 8'hCC);
      probe(20'hC8000, 1'b0, 1'b0, "R3");
      probe(20'hCC000, 1'b0, 1'b0, "R3");
      cfg(8'h5F, 8'h32);
      probe(20'hEC000, 1'b0, 1'b0, "R4");
      probe(20'hEFFFF, 1'b0, 1'b0, "R3");

      // R2: top segment uses bits 5:4 only
      cfg(8'h59, 8'h0F);
      probe(20'hF0000, 1'b0, 1'b0, "R2");
      cfg(8'h59, 8'h10);
      probe(20'hF8000, 1'b0, 1'b1, "R9");
      probe(20'hFFFFF, 1'b0, 1'b0, "R9");

      // R7: other offsets ignored
      cfg(8'h58, 8'hFF);
      cfg(8'h60, 8'hFF);
      cfg(8'h71, 8'hFF);
      cfg(8'h73, 8'hFF);
      probe(20'hA0000, 1'b1, 1'b0, "R7");
      probe(20'hF0000, 1'b0, 1'b0, "R7");
      probe(20'hD0000, 1'b0, 1'b0, "R7");

      // R5 R8: mode-gated window, toggled without an intervening write
      cfg(8'h72, 8'h08);
      probe(20'hA8000, 1'b0, 1'b0, "R8");
      probe(20'hA8000, 1'b1, 1'b1, "R8");
      probe(20'hBFFFF, 1'b0, 1'b1, "R8");
      cfg(8'h72, 8'h40);
      probe(20'hA0000, 1'b0, 1'b1, "R5");
      probe(20'hB0000, 1'b1, 1'b0, "R5");
      cfg(8'h72, 8'hB7);
      probe(20'hA0000, 1'b1, 1'b0, "R5");

      // R10: idle access produces no strobe
      step(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 20'hC0000, "R10");

      // seeded random mix
      for (int n = 0; n < N_RANDOM; n++) begin
         logic we, smm, v, wr;
         logic [7:0] ofs, wd;
         logic [19:0] a;
         int k;
         we  = ($urandom % 100) < 30;
         k   = int'($urandom % 10);
         if (k < 6)      ofs = 8'h59 + 8'($urandom % 7);
         else if (k < 8) ofs = 8'h72;
         else            ofs = 8'h50 + 8'($urandom % 48);
         wd  = 8'($urandom);
         smm = ($urandom % 2) == 1;
         v   = ($urandom % 8) != 0;
         wr  = ($urandom % 2) == 1;
         if (($urandom % 4) == 0) a = 20'($urandom % 32'hA0000);
         else                     a = 20'hA0000 + 20'($urandom % 32'h60000);
         step(we, ofs, wd, smm, v, wr, a, we ? "R7" : region_tag(a));
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule